// File: doc/BRIEF.md
# Sparsified Hit Channel Readout Sequencer

This block sits beside a bank of 32 channel discriminators. It turns their hit pulses into held flags and then walks through the channels one at a time so that each channel can be read out. Each hit input passes through a synchroniser. A rising edge on a channel whose enable mask allows it sets that channel's flag, and the flag stays set until a clear. A fast OR of all flags and a binary count of the set flags are available at all times. They can be used for triggering and to estimate multiplicity.

A start command snapshots the set of channels to visit. One mode control picks between visiting only the hit channels (sparse) and visiting every channel (full). While the walk is in progress, the block presents the current channel as a 5-bit address. It also drives a one-hot select line back to that channel. Each advance strobe moves to the next channel in ascending order. After the last channel has been passed, the block raises a done flag. A clear returns the flags, the count and the walk to idle in one cycle.

Top module: `hit_readout_seq`

## Requirements
- R1: A channel flag is set three clock edges after its hit input first goes high, when two synchroniser stages are used. Only a rising edge sets the flag. The flag then stays set while the input stays high, falls or rises again, until a clear.
- R2: A channel whose mask bit in `ch_disable` is 1 never sets its flag, however it is pulsed. Later re-enabling that channel does not recover a hit that arrived while it was masked.
- R3: `any_hit` is 1 exactly when at least one channel flag is set.
- R4: `hit_count` equals the number of set channel flags, from 0 to 32, as an unsigned binary value.
- R5: With `sparse_mode`=1, `start` presents the lowest-numbered flagged channel on `ch_addr` with `valid`=1 on the next cycle. Each `advance` then moves to the next higher flagged channel.
- R6: With `sparse_mode`=0, a walk visits channels 0, 1, ..., 31 in that order, whatever the flags are.
- R7: While `valid`=1, `ch_sel` has exactly one bit set, at the position given by `ch_addr`. While `valid`=0, `ch_sel` is all zeros.
- R8: An advance on the last channel of a walk gives `done`=1 and `valid`=0 on the next cycle. A sparse walk started with no flags set gives `done`=1 on the cycle after `start`.
- R9: An `advance` while done or idle changes neither `done`, `valid`, `ch_addr` nor the flags.
- R10: `clear` zeroes all flags, `any_hit` and `hit_count`, and returns the walk to idle (`valid`=0, `done`=0) on the next cycle. `clear` takes priority over `start` and `advance`.
- R11: After reset all flags are clear, `hit_count`=0, `any_hit`=0, `valid`=0, `done`=0 and `ch_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | 32 | Asynchronous hit pulses, one per channel |
| ch_disable | input | 32 | Per-channel mask, 1 = ignore that channel's hits |
| sparse_mode | input | 1 | 1 = visit flagged channels only, 0 = visit all channels |
| start | input | 1 | Begin a walk, sampled on the clock edge |
| advance | input | 1 | Move to the next channel |
| clear | input | 1 | Zero all flags and return the walk to idle |
| any_hit | output | 1 | OR of all channel flags |
| hit_count | output | 6 | Number of set channel flags |
| ch_addr | output | 5 | Encoded address of the current channel |
| ch_sel | output | 32 | One-hot select back to the current channel |
| valid | output | 1 | A channel is being presented |
| done | output | 1 | The walk has no channel left |

## Verification
A corrupted pending-channel register shows at the ports within one advance. The address then skips a flagged channel, repeats one, or moves backwards. The walk may also end early or late compared with the bench's own list of expected channels. A stuck or wrongly set flag changes `hit_count` and `any_hit` on the cycle after the flag register updates. A decoder or state fault shows at once as a `ch_sel` that does not match `ch_addr`, or as `valid` and `done` being high together.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SCAN = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/hrs_hit_capture.sv
// Synchronises hit pulses, detects rising edges and holds per-channel flags.
module hrs_hit_capture #(
  parameter int NUM_CH      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_in,
  input  logic [NUM_CH-1:0] ch_disable,
  input  logic              clear,
  output logic [NUM_CH-1:0] flags
);
  logic [SYNC_STAGES-1:0][NUM_CH-1:0] sync_q, sync_d;
  logic [NUM_CH-1:0] prev_q;
  logic [NUM_CH-1:0] rise;
  logic [NUM_CH-1:0] flags_q, flags_d;
  logic              flags_en;

  always_comb begin
    sync_d[0] = hit_in;
    for (int s = 1; s < SYNC_STAGES; s++) begin
      sync_d[s] = sync_q[s-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_comb begin
    flags_en = clear | (|(rise & ~ch_disable));
    if (clear) flags_d = '0;
    else       flags_d = flags_q | (rise & ~ch_disable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/hrs_popcount.sv
// Counts the set bits of a vector.
module hrs_popcount #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CNT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/hrs_lowest_set.sv
// Priority encoder: index of the lowest set bit.
module hrs_lowest_set #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hrs_onehot_dec.sv
// Address to one-hot select decoder with an enable.
module hrs_onehot_dec #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     sel
);
  for (genvar g = 0; g < W; g++) begin : g_line
    assign sel[g] = en && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/hrs_sequencer.sv
// Walks the pending channel set in ascending order.
module hrs_sequencer
  import hrs_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] flags,
  input  logic              sparse_mode,
  input  logic              start,
  input  logic              advance,
  input  logic              clear,
  output logic [ADDR_W-1:0] ch_addr,
  output logic              valid,
  output logic              done
);
  seq_state_e        state_q, state_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic              seq_en;
  logic              found;

  hrs_lowest_set #(.W(NUM_CH), .IDX_W(ADDR_W)) i_first (
    .vec   (pend_q),
    .idx   (ch_addr),
    .found (found)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    seq_en  = 1'b0;
    if (clear) begin
      seq_en  = 1'b1;
      pend_d  = '0;
      state_d = SEQ_IDLE;
    end else if (start) begin
      seq_en  = 1'b1;
      pend_d  = sparse_mode ? flags : '1;
      state_d = (pend_d != '0) ? SEQ_SCAN : SEQ_DONE;
    end else if (advance && state_q == SEQ_SCAN) begin
      seq_en  = 1'b1;
      pend_d  = pend_q & (pend_q - 1'b1);
      state_d = (pend_d != '0) ? SEQ_SCAN : SEQ_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign valid = (state_q == SEQ_SCAN) && found;
  assign done  = (state_q == SEQ_DONE);
endmodule

// File: rtl/hit_readout_seq.sv
module hit_readout_seq #(
  parameter int NUM_CH      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_CH),
  localparam int CNT_W      = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_in,
  input  logic [NUM_CH-1:0] ch_disable,
  input  logic              sparse_mode,
  input  logic              start,
  input  logic              advance,
  input  logic              clear,
  output logic              any_hit,
  output logic [CNT_W-1:0]  hit_count,
  output logic [ADDR_W-1:0] ch_addr,
  output logic [NUM_CH-1:0] ch_sel,
  output logic              valid,
  output logic              done
);
  logic [NUM_CH-1:0] flags;

  hrs_hit_capture #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) i_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_in     (hit_in),
    .ch_disable (ch_disable),
    .clear      (clear),
    .flags      (flags)
  );

  assign any_hit = |flags;

  hrs_popcount #(.W(NUM_CH), .CNT_W(CNT_W)) i_count (
    .vec   (flags),
    .count (hit_count)
  );

  hrs_sequencer #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .flags       (flags),
    .sparse_mode (sparse_mode),
    .start       (start),
    .advance     (advance),
    .clear       (clear),
    .ch_addr     (ch_addr),
    .valid       (valid),
    .done        (done)
  );

  hrs_onehot_dec #(.W(NUM_CH), .IDX_W(ADDR_W)) i_dec (
    .en  (valid),
    .idx (ch_addr),
    .sel (ch_sel)
  );
endmodule

// File: rtl/hrs_checker.sv
module hrs_checker #(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              advance,
  input logic              clear,
  input logic              any_hit,
  input logic [CNT_W-1:0]  hit_count,
  input logic [ADDR_W-1:0] ch_addr,
  input logic [NUM_CH-1:0] ch_sel,
  input logic              valid,
  input logic              done
);
  a_r7_sel_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones(ch_sel) == 1 && ch_sel[ch_addr]));

  a_r7_sel_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (ch_sel == '0));

  a_r3_or_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit == (hit_count != '0));

  a_r8_done_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && valid));

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && advance && !start && !clear) |=> (!valid || ch_addr > $past(ch_addr)));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !clear) |=> done);

  a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (hit_count == '0 && !any_hit && !valid && !done));
endmodule

bind hit_readout_seq hrs_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_hrs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .advance   (advance),
  .clear     (clear),
  .any_hit   (any_hit),
  .hit_count (hit_count),
  .ch_addr   (ch_addr),
  .ch_sel    (ch_sel),
  .valid     (valid),
  .done      (done)
);

// File: tb/test_hit_readout_seq.sv
module test_hit_readout_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] hit_in;
  logic [31:0] ch_disable;
  logic        sparse_mode;
  logic        start;
  logic        advance;
  logic        clear;
  logic        any_hit;
  logic [5:0]  hit_count;
  logic [4:0]  ch_addr;
  logic [31:0] ch_sel;
  logic        valid;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hit_readout_seq i_hit_readout_seq (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .ch_disable(ch_disable),
    .sparse_mode(sparse_mode), .start(start), .advance(advance), .clear(clear),
    .any_hit(any_hit), .hit_count(hit_count), .ch_addr(ch_addr), .ch_sel(ch_sel),
    .valid(valid), .done(done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_hits(logic [31:0] m);
    hit_in = m;
    step();
    hit_in = '0;
    repeat (4) step();
  endtask

  task automatic do_clear();
    clear = 1'b1;
    step();
    clear = 1'b0;
  endtask

  task automatic do_start(logic sparse);
    sparse_mode = sparse;
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic do_advance();
    advance = 1'b1;
    step();
    advance = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 count", hit_count, 0);
    chk("R11 any_hit", any_hit, 0);
    chk("R11 valid", valid, 0);
    chk("R11 done", done, 0);
    chk("R11 ch_sel", ch_sel, 0);
  endtask

  task automatic t_capture();
    do_clear();
    hit_in = 32'h0000_0010;
    step(); step();
    chk("R1 not yet", hit_count, 0);
    step();
    chk("R1 set after three edges", hit_count, 1);
    repeat (6) step();
    hit_in = '0;
    repeat (3) step();
    chk("R1 held", hit_count, 1);
    pulse_hits(32'h0000_0010);
    chk("R1 repeat same channel", hit_count, 1);
    pulse_hits(32'h8000_0401);
    chk("R4 count", hit_count, 4);
    chk("R3 any_hit", any_hit, 1);
    pulse_hits(32'hFFFF_FFFF);
    chk("R4 count full", hit_count, 32);
  endtask

  task automatic t_mask();
    do_clear();
    chk("R3 any_hit clear", any_hit, 0);
    ch_disable = 32'h0000_0020;
    pulse_hits(32'h0000_0060);
    chk("R2 masked count", hit_count, 1);
    ch_disable = '0;
    repeat (3) step();
    chk("R2 no recovery", hit_count, 1);
    do_start(1'b1);
    chk("R2 first channel", ch_addr, 6);
    chk("R2 valid", valid, 1);
  endtask

  task automatic t_sparse();
    logic [4:0] exp_list [4] = '{5'd3, 5'd7, 5'd8, 5'd31};
    do_clear();
    pulse_hits(32'h8000_0188);
    do_start(1'b1);
    for (int k = 0; k < 4; k++) begin
      chk("R5 address", ch_addr, exp_list[k]);
      chk("R5 valid", valid, 1);
      chk("R7 select", ch_sel, 32'h1 << exp_list[k]);
      chk("R8 not done", done, 0);
      do_advance();
    end
    chk("R8 done", done, 1);
    chk("R8 valid low", valid, 0);
    chk("R7 select zero", ch_sel, 0);
  endtask

  task automatic t_full();
    do_clear();
    pulse_hits(32'h0000_0004);
    do_start(1'b0);
    for (int k = 0; k < 32; k++) begin
      chk("R6 address", ch_addr, k);
      chk("R6 valid", valid, 1);
      chk("R7 select", ch_sel, 32'h1 << k);
      do_advance();
    end
    chk("R8 full done", done, 1);
    chk("R8 full valid", valid, 0);
  endtask

  task automatic t_empty();
    do_clear();
    do_start(1'b1);
    chk("R8 empty done", done, 1);
    chk("R8 empty valid", valid, 0);
  endtask

  task automatic t_ignore();
    repeat (3) do_advance();
    chk("R9 done kept", done, 1);
    chk("R9 valid kept", valid, 0);
    do_clear();
    pulse_hits(32'h0000_0200);
    do_advance();
    chk("R9 idle valid", valid, 0);
    chk("R9 idle done", done, 0);
    chk("R9 flags kept", hit_count, 1);
    do_start(1'b1);
    do_advance();
    chk("R9 reach done", done, 1);
    do_advance();
    chk("R9 done after extra", done, 1);
    chk("R9 count after extra", hit_count, 1);
  endtask

  task automatic t_clear();
    do_clear();
    pulse_hits(32'h0000_0F00);
    do_start(1'b1);
    chk("R10 walk running", ch_addr, 8);
    do_clear();
    chk("R10 count", hit_count, 0);
    chk("R10 any_hit", any_hit, 0);
    chk("R10 valid", valid, 0);
    chk("R10 done", done, 0);
    pulse_hits(32'h0000_0001);
    clear = 1'b1; start = 1'b1; advance = 1'b1;
    step();
    clear = 1'b0; start = 1'b0; advance = 1'b0;
    chk("R10 priority valid", valid, 0);
    chk("R10 priority done", done, 0);
    chk("R10 priority count", hit_count, 0);
  endtask

  initial begin
    rst_n = 1'b0; hit_in = '0; ch_disable = '0; sparse_mode = 1'b1;
    start = 1'b0; advance = 1'b0; clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_capture();
    t_mask();
    t_sparse();
    t_full();
    t_empty();
    t_ignore();
    t_clear();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule